// File: doc/BRIEF.md
# SPI Frame Buffer Access Slave

This block is the serial front end of a packet frame buffer. A host talks to it over a four-wire SPI link in mode 0 (clock idles low, data sampled on the rising edge, changed on the falling edge, most significant bit first). Each transaction lasts while the active-low select is held low and begins with a command byte. While that command byte shifts in, the block shifts out a status byte built from an external three-bit state input. The command then selects either a frame read or a frame write for the rest of the transaction.

A frame write sends a length byte followed by payload bytes, which are stored in order. A frame read returns the stored length, the payload bytes up to that length, and then a link-quality byte. A byte counter inside the block advances on every data byte, and every new transaction starts it again at the length field. A separate byte-wide load port lets a receive path place a new length, payload bytes and quality byte into the buffer. That port is locked out while a host frame write is in progress.

The SPI pins are sampled with the system clock through synchronisers, so the whole block lives in one clock domain. The SPI clock must be several times slower than the system clock.

Top module: `spi_fbuf_slave`

## Requirements
- R1: While select is high, MISO is low. After reset the stored length and quality byte are zero.
- R2: During the command byte, MISO carries the status byte, with `link_state` in bits [2:0] and zeros above, most significant bit first. MISO changes only after a falling SCLK edge or a select edge, and MOSI is taken on rising SCLK edges.
- R3: The command byte is decoded from its bits [7:5]: 3'b001 is a frame read, 3'b011 is a frame write, and bits [4:0] are don't-care. Any other command drives MISO low for the rest of the transaction and leaves the buffer unchanged.
- R4: After a read command, MISO returns the length byte, then payload bytes 1 to L, then the quality byte, then 0x00 for every further byte, where L is the stored length.
- R5: Every read transaction starts at the length field. Ending a read early, even right after the length byte, leaves the buffer unchanged.
- R6: After a write command, the first data byte becomes the length, with bit 7 dropped. Data bytes 2 to L+1 are stored as payload bytes 1 to L.
- R7: In a write, data bytes past the declared length are discarded and leave the stored payload unchanged. The full 127-byte frame is accepted.
- R8: A load-port write with `rx_addr` 0 sets the length (bit 7 dropped), with 1 to 127 sets that payload byte, and with 128 sets the quality byte. It takes effect when no host frame write is in progress.
- R9: Load-port writes issued after a write command has been decoded, and before select rises, are ignored.
- R10: The quality byte changes only through the load port. A host frame write never alters it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, low when idle |
| link_state | input | 3 | State value sent in the status byte |
| rx_we | input | 1 | Load-port write strobe |
| rx_addr | input | 8 | Load-port target: 0 length, 1..127 payload, 128 quality |
| rx_data | input | 8 | Load-port write data |

## Verification
The bound checker watches four behaviours on every cycle:
- MISO stays low once select has been high for a few cycles.
- MISO only moves after an SCLK fall or a select edge.
- MISO stays quiet after an unrecognised command.
- The quality byte holds while load-port writes arrive during a host write.

The internal byte counter is also checked never to step backwards inside a transaction. What only the bench scenarios can show is the byte-level content:
- The status, length, payload and quality sequence of a read, including the 127-byte limit.
- The discarding of surplus write bytes, which is made visible by lengthening the frame through the load port.
- The restart at the length field after an aborted read.
- The fact that commands with don't-care low bits still work.

// File: rtl/spi_fbuf_slave.sv
module spi_fbuf_slave #(
  parameter int FRAME_MAX = 127,
  parameter int SYNC_STAGES = 2,
  parameter int STW = 3,
  parameter logic [2:0] CMD_RD = 3'b001,
  parameter logic [2:0] CMD_WR = 3'b011,
  localparam int LW = $clog2(FRAME_MAX + 1),
  localparam int AW = $clog2(FRAME_MAX + 2),
  localparam int CW = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           spi_sclk,
  input  logic           spi_cs_n,
  input  logic           spi_mosi,
  output logic           spi_miso,
  input  logic [STW-1:0] link_state,
  input  logic           rx_we,
  input  logic [AW-1:0]  rx_addr,
  input  logic [7:0]     rx_data
);

  localparam logic [AW-1:0] LQI_ADDR = AW'(FRAME_MAX + 1);
  localparam logic [CW-1:0] IDX_SAT  = CW'(FRAME_MAX + 2);

  typedef enum logic [1:0] {M_CMD, M_READ, M_WRITE, M_IGN} mode_t;

  logic [SYNC_STAGES-1:0] sck_sy, csn_sy, mosi_sy;
  logic sck_d, cs_act;
  logic sck_now, cs_now, mosi_now;
  logic sck_rise, sck_fall, cs_go, cs_end;

  mode_t       mode;
  logic [2:0]  bitc;
  logic        byte_pend;
  logic [CW-1:0] idx;
  logic [6:0]  sh_in;
  logic [7:0]  tx_sr;
  logic [7:0]  byte_in, next_byte;
  logic        byte_done, wr_byte, wr_busy;

  logic [LW-1:0] len_q;
  logic [7:0]    lqi_q;
  logic [7:0]    pay [1:FRAME_MAX];
  logic [CW-1:0] len_ext;

  function automatic logic [LW-1:0] clamp_len(input logic [7:0] b);
    return (b[LW-1:0] > LW'(FRAME_MAX)) ? LW'(FRAME_MAX) : b[LW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      csn_sy  <= '1;
      mosi_sy <= '0;
      sck_d   <= 1'b0;
      cs_act  <= 1'b0;
    end else begin
      sck_sy  <= {sck_sy[SYNC_STAGES-2:0], spi_sclk};
      csn_sy  <= {csn_sy[SYNC_STAGES-2:0], spi_cs_n};
      mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], spi_mosi};
      sck_d   <= sck_now;
      cs_act  <= cs_now;
    end
  end

  assign sck_now  = sck_sy[SYNC_STAGES-1];
  assign cs_now   = ~csn_sy[SYNC_STAGES-1];
  assign mosi_now = mosi_sy[SYNC_STAGES-1];
  assign sck_rise = sck_now & ~sck_d;
  assign sck_fall = ~sck_now & sck_d;
  assign cs_go    = cs_now & ~cs_act;
  assign cs_end   = ~cs_now & cs_act;

  assign byte_in   = {sh_in, mosi_now};
  assign byte_done = cs_act & cs_now & sck_rise & (bitc == 3'd7);
  assign wr_byte   = byte_done & (mode == M_WRITE);
  assign wr_busy   = cs_act & (mode == M_WRITE);
  assign len_ext   = CW'(len_q);
  assign spi_miso  = tx_sr[7] & cs_act;

  always_comb begin
    next_byte = 8'h00;
    if (mode == M_READ) begin
      if (idx == '0)                next_byte = 8'(len_q);
      else if (idx <= len_ext)      next_byte = pay[idx[LW-1:0]];
      else if (idx == len_ext + 1'b1) next_byte = lqi_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= M_CMD;
      bitc      <= '0;
      byte_pend <= 1'b0;
      idx       <= '0;
      sh_in     <= '0;
      tx_sr     <= '0;
    end else if (!cs_now) begin
      mode      <= M_CMD;
      bitc      <= '0;
      byte_pend <= 1'b0;
      idx       <= '0;
      tx_sr     <= '0;
    end else if (cs_go) begin
      tx_sr     <= 8'(link_state);
      mode      <= M_CMD;
      bitc      <= '0;
      byte_pend <= 1'b0;
      idx       <= '0;
    end else if (sck_rise) begin
      sh_in <= byte_in[6:0];
      bitc  <= bitc + 3'd1;
      if (bitc == 3'd7) begin
        byte_pend <= 1'b1;
        if (mode == M_CMD) begin
          if (byte_in[7:5] == CMD_RD)      mode <= M_READ;
          else if (byte_in[7:5] == CMD_WR) mode <= M_WRITE;
          else                             mode <= M_IGN;
        end else if (mode == M_WRITE && idx < IDX_SAT) begin
          idx <= idx + 1'b1;
        end
      end
    end else if (sck_fall) begin
      if (byte_pend) begin
        tx_sr     <= next_byte;
        byte_pend <= 1'b0;
        if (mode == M_READ && idx < IDX_SAT) idx <= idx + 1'b1;
      end else begin
        tx_sr <= {tx_sr[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
      lqi_q <= '0;
      for (int i = 1; i <= FRAME_MAX; i++) pay[i] <= '0;
    end else if (wr_byte) begin
      if (idx == '0)           len_q <= clamp_len(byte_in);
      else if (idx <= len_ext) pay[idx[LW-1:0]] <= byte_in;
    end else if (rx_we && !wr_busy) begin
      if (rx_addr == '0)                     len_q <= clamp_len(rx_data);
      else if (rx_addr == LQI_ADDR)          lqi_q <= rx_data;
      else if (rx_addr <= AW'(FRAME_MAX))    pay[rx_addr[LW-1:0]] <= rx_data;
    end
  end

endmodule

module spi_fbuf_chk #(
  parameter int AW = 8,
  parameter int CW = 9,
  parameter logic [7:0] LQI_ADDR = 8'd128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_cs_n,
  input logic          spi_miso,
  input logic          rx_we,
  input logic [AW-1:0] rx_addr,
  input logic          sck_fall,
  input logic          cs_go,
  input logic          cs_end,
  input logic          cs_act,
  input logic [1:0]    mode,
  input logic          byte_pend,
  input logic          wr_busy,
  input logic [7:0]    lqi_q,
  input logic [CW-1:0] idx
);
  logic       armed;
  logic [2:0] idle_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      idle_run <= '0;
    end else begin
      armed <= 1'b1;
      if (!spi_cs_n)              idle_run <= '0;
      else if (idle_run != 3'd7)  idle_run <= idle_run + 3'd1;
    end
  end

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_run >= 3'd4) |-> !spi_miso);

  p_miso_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$stable(spi_miso)) |-> ($past(sck_fall) || $past(cs_go) || $past(cs_end)));

  p_ign_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && mode == 2'd3 && !byte_pend) |-> !spi_miso);

  p_idx_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cs_act && $past(cs_act)) |-> (idx >= $past(idx)));

  p_rx_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && rx_we && rx_addr == AW'(LQI_ADDR)) |=> $stable(lqi_q));
endmodule

bind spi_fbuf_slave spi_fbuf_chk #(.AW($bits(rx_addr)), .CW($bits(idx))) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .rx_we(rx_we), .rx_addr(rx_addr), .sck_fall(sck_fall), .cs_go(cs_go),
  .cs_end(cs_end), .cs_act(cs_act), .mode(mode), .byte_pend(byte_pend),
  .wr_busy(wr_busy), .lqi_q(lqi_q), .idx(idx)
);

// File: tb/tb_spi_fbuf_slave.sv
module tb_spi_fbuf_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [2:0] phy_state = 3'd0;
  logic rx_we = 1'b0;
  logic [7:0] rx_addr = 8'd0, rx_data = 8'd0;

  always #2.5 clk = ~clk;

  spi_fbuf_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .link_state(phy_state),
    .rx_we(rx_we), .rx_addr(rx_addr), .rx_data(rx_data)
  );

  int n_chk = 0, n_fail = 0;
  int m_len = 0;
  logic [7:0] m_pay [1:127];
  logic [7:0] m_lqi = 8'h00;
  int idle_cnt = 0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_rd(input int j);
    if (j == 0) return 8'(m_len);
    if (j <= m_len) return m_pay[j];
    if (j == m_len + 1) return m_lqi;
    return 8'h00;
  endfunction

  // R1: per-clock comparison of the idle line
  always @(negedge clk) begin
    if (rst_n && cs_n) idle_cnt++;
    else idle_cnt = 0;
    if (idle_cnt > 5) check("R1 idle MISO", {7'd0, miso}, 8'h00);
  end

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) mosi = tx[i];
      repeat (6) @(negedge clk);
      rx[i] = miso;
      @(negedge clk) sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic txn(input logic [7:0] cmd, input logic [7:0] data[$], input string req);
    logic [7:0] r, e;
    int kind;
    kind = (cmd[7:5] == 3'b001) ? 1 : (cmd[7:5] == 3'b011) ? 2 : 0;
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
    e = {5'd0, phy_state};
    xfer(cmd, r);
    check("R2 status byte", r, e);
    foreach (data[j]) begin
      e = (kind == 1) ? m_rd(j) : 8'h00;
      xfer(data[j], r);
      check(req, r, e);
      if (kind == 2) begin
        if (j == 0) m_len = int'(data[j][6:0]);
        else if (j <= m_len) m_pay[j] = data[j];
      end
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic rx_put(input int a, input logic [7:0] d, input bit apply);
    @(negedge clk);
    rx_we = 1'b1; rx_addr = 8'(a); rx_data = d;
    @(negedge clk);
    rx_we = 1'b0;
    if (apply) begin
      if (a == 0) m_len = int'(d[6:0]);
      else if (a == 128) m_lqi = d;
      else if (a <= 127) m_pay[a] = d;
    end
  endtask

  task automatic read_n(input logic [7:0] cmd, input int n, input string req);
    logic [7:0] q[$];
    for (int k = 0; k < n; k++) q.push_back(8'hFF);
    txn(cmd, q, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    for (int i = 1; i <= 127; i++) m_pay[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 reset MISO", {7'd0, miso}, 8'h00);

    phy_state = 3'd5;
    read_n(8'h20, 3, "R1 reset length/quality zero");

    phy_state = 3'd2;
    rx_put(0, 8'h04, 1);
    for (int i = 1; i <= 4; i++) rx_put(i, 8'hA0 + 8'(i), 1);
    rx_put(128, 8'h5C, 1);
    read_n(8'h20, 8, "R4 R8 loaded frame read");

    phy_state = 3'd7;
    read_n(8'h3F, 1, "R3 R5 early-ended read");
    read_n(8'h20, 6, "R5 read restarts at length");

    phy_state = 3'd1;
    q = {8'h06, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h77, 8'h88, 8'h99};
    txn(8'h60, q, "R6 write MISO low");
    rx_put(0, 8'h09, 1);
    read_n(8'h20, 12, "R7 R10 surplus discarded, quality kept");

    q = {8'h85, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
    txn(8'h7F, q, "R6 write bit7 length");
    read_n(8'h20, 8, "R6 length bit7 dropped");

    phy_state = 3'd4;
    q = {8'h03, 8'h44, 8'h55};
    txn(8'h40, q, "R3 unknown command 0x40 quiet");
    txn(8'hA0, q, "R3 unknown command 0xA0 quiet");
    txn(8'h00, q, "R3 unknown command 0x00 quiet");
    read_n(8'h20, 8, "R3 buffer unchanged");

    q = {8'h02, 8'hC1, 8'hC2, 8'hC3, 8'hC4};
    fork
      txn(8'h60, q, "R9 write with load collisions");
      begin
        repeat (300) @(negedge clk);
        rx_put(128, 8'hEE, 0);
        rx_put(1, 8'hEE, 0);
        rx_put(0, 8'h07, 0);
      end
    join
    read_n(8'h20, 5, "R9 load port ignored during write");
    rx_put(128, 8'h3A, 1);
    read_n(8'h20, 5, "R8 quality load after write");

    phy_state = 3'd6;
    q.delete();
    q.push_back(8'h7F);
    for (int i = 1; i <= 127; i++) q.push_back(8'(i * 3 + 7));
    q.push_back(8'hAA);
    q.push_back(8'hAA);
    txn(8'h60, q, "R7 full frame write");
    read_n(8'h20, 131, "R7 R4 full frame read");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule